// File: doc/BRIEF.md
# ATA Identify Field Extractor

This block fetches one descriptive field from an 8-bit PIO ATA or CompactFlash device. A host asks for a field with a small selector code. The block then writes the IDENTIFY DEVICE command and polls the device status until data is ready. It clocks the whole 512-byte identify response off the device, one byte per read strobe. Only the 16-bit words inside the window for the chosen field are passed on. They leave on a valid/ready byte stream. Text fields come out with the two bytes of each word exchanged, so the characters appear in reading order.

The device side is a plain register port. It has a 3-bit register address, two active-low chip selects, active-low read and write strobes, and an 8-bit data bus with an output enable. Chip select 0 reaches the command block registers. Chip select 1 reaches the control block, where the alternate status register sits at address 6. The strobe width and the recovery gap between accesses are set in clock cycles by parameters. The status poll gives up after a cycle count set by a parameter; the default is one second at 250 MHz. Every request ends with a one-cycle response that carries a result code.

Top module: `ata_ident_fetch`

## Requirements
- R1: A request whose selector is 4 to 7 is accepted. In the very next cycle `resp_valid` is high with `resp_code` = 1 (parameter error). No chip select or strobe is driven for that request, and no byte is output.
- R2: The first bus access of a valid request is a single write of 0xEC to register address 7 with chip select 0.
- R3: After the command, the block reads status (chip select 0, address 7) repeatedly. It moves on only when a status value has bit 7 (busy) clear and bit 3 (data request) set. No data register read occurs before that status value has been seen, and no further status poll follows it.
- R4: If the device is still not ready once TIMEOUT_CYC cycles have passed after the command, the request ends with `resp_code` = 2 (timeout). No data register read happens and no byte is output.
- R5: A request that reaches the data phase performs exactly 512 reads of data register address 0, whatever the selected window is.
- R6: Selector 0 outputs words 60 to 61. Selector 1 outputs words 23 to 26. Selector 2 outputs words 27 to 46. Selector 3 outputs words 10 to 19. Word w is made of the bytes read by data strobes 2w (even, low) and 2w+1 (odd, high).
- R7: Selector 0 outputs each word's even byte first and then its odd byte. Selectors 1, 2 and 3 output the odd byte first and then the even byte.
- R8: `out_last` is high only with the final byte of the window. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R9: After the 512th data read, the block performs exactly one alternate status read (chip select 1, address 6), then exactly one status read (chip select 0, address 7). It then ends with `resp_code` = 0 (success).
- R10: A strobe is low only while exactly one chip select is low. The address is held for the whole strobe, and each strobe stays low for exactly STROBE_CYC cycles.
- R11: After reset, and again whenever no request is in progress, `req_ready` is high and the bus is idle. While a request is in progress `req_ready` is low, and any other request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_sel | input | 3 | Field selector (0 capacity, 1 revision, 2 model, 3 serial) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of the field |
| resp_valid | output | 1 | One-cycle end-of-request pulse |
| resp_code | output | 2 | Result: 0 success, 1 parameter error, 2 timeout |
| dev_addr | output | 3 | Device register address |
| dev_cs0_n | output | 1 | Command block chip select, active low |
| dev_cs1_n | output | 1 | Control block chip select, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | 8 | Write data to the device |
| dev_doe | output | 1 | Drive enable for dev_dout |
| dev_din | input | 8 | Read data from the device |

## Verification
All four field selectors are requested from a modelled device. The model's identify bytes differ between every strobe position and between the two halves of the response. Because of this, a window that is off by one word, a lost swap, or a swap applied to the capacity field each produce a different byte. Ready-time patterns of zero to five not-ready polls are tried, using status values with busy and data-request both set and with neither set. These show whether each bit is checked on its own. The output is run both with constant ready and with a stalling ready pattern, to separate byte-order errors from hold errors. Selector codes out of range, a device that never becomes ready, and a request made while busy cover the paths that must produce no bus or output activity.

// File: rtl/ata_id_pkg.sv
package ata_id_pkg;

   localparam int SEL_W  = 3;
   localparam int WORD_W = 8;

   localparam logic [7:0] CMD_IDENTIFY = 8'hEC;
   localparam logic [2:0] ADR_DATA     = 3'd0;
   localparam logic [2:0] ADR_STATUS   = 3'd7;
   localparam logic [2:0] ADR_ALTSTAT  = 3'd6;
   localparam int         BIT_BSY      = 7;
   localparam int         BIT_DRQ      = 3;

   typedef enum logic [1:0] {
      RC_OK      = 2'd0,
      RC_PARAM   = 2'd1,
      RC_TIMEOUT = 2'd2
   } resp_code_e;

   typedef struct packed {
      logic              ok;
      logic              swap;
      logic [WORD_W-1:0] first;
      logic [WORD_W-1:0] count;
   } win_t;

   function automatic win_t field_window(input logic [SEL_W-1:0] sel);
      win_t w;
      w = '0;
      case (sel)
         3'd0: begin w.ok = 1'b1; w.swap = 1'b0; w.first = WORD_W'(60); w.count = WORD_W'(2);  end
         3'd1: begin w.ok = 1'b1; w.swap = 1'b1; w.first = WORD_W'(23); w.count = WORD_W'(4);  end
         3'd2: begin w.ok = 1'b1; w.swap = 1'b1; w.first = WORD_W'(27); w.count = WORD_W'(20); end
         3'd3: begin w.ok = 1'b1; w.swap = 1'b1; w.first = WORD_W'(10); w.count = WORD_W'(10); end
         default: w = '0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/ata_bus_cycle.sv
module ata_bus_cycle #(
   parameter int STROBE_CYC = 3,
   parameter int RECOV_CYC  = 2,
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic              alt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              dev_cs0_n,
   output logic              dev_cs1_n,
   output logic              dev_rd_n,
   output logic              dev_wr_n,
   output logic [DATA_W-1:0] dev_dout,
   output logic              dev_doe,
   input  logic [DATA_W-1:0] dev_din
);

   localparam int MAXC  = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);

   generate
      if (STROBE_CYC < 1 || RECOV_CYC < 1) begin : g_bad_timing
         $error("ata_bus_cycle: strobe and recovery need at least one cycle");
      end
   endgenerate

   typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_RECOV} bstate_e;

   bstate_e          st;
   logic [CNT_W-1:0] cnt;
   logic             wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= B_IDLE;
         cnt       <= '0;
         wr_q      <= 1'b0;
         done      <= 1'b0;
         rdata     <= '0;
         dev_addr  <= '0;
         dev_cs0_n <= 1'b1;
         dev_cs1_n <= 1'b1;
         dev_rd_n  <= 1'b1;
         dev_wr_n  <= 1'b1;
         dev_dout  <= '0;
         dev_doe   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            B_IDLE: begin
               if (start) begin
                  st        <= B_SETUP;
                  wr_q      <= wr;
                  dev_cs0_n <= alt;
                  dev_cs1_n <= !alt;
                  dev_addr  <= addr;
                  dev_dout  <= wdata;
                  dev_doe   <= wr;
               end
            end
            B_SETUP: begin
               st  <= B_STROBE;
               cnt <= CNT_W'(STROBE_CYC - 1);
               if (wr_q) dev_wr_n <= 1'b0;
               else      dev_rd_n <= 1'b0;
            end
            B_STROBE: begin
               if (cnt == '0) begin
                  st       <= B_RECOV;
                  cnt      <= CNT_W'(RECOV_CYC - 1);
                  dev_rd_n <= 1'b1;
                  dev_wr_n <= 1'b1;
                  if (!wr_q) rdata <= dev_din;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (cnt == '0) begin
                  st        <= B_IDLE;
                  done      <= 1'b1;
                  dev_cs0_n <= 1'b1;
                  dev_cs1_n <= 1'b1;
                  dev_doe   <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = (st != B_IDLE);

   // strobe width checker counter
   logic [CNT_W:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      low_run <= '0;
      else if (!dev_rd_n || !dev_wr_n) low_run <= low_run + 1'b1;
      else                             low_run <= '0;
   end

   assert_strobe_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_rd_n && dev_wr_n && low_run != '0) |-> (low_run == (CNT_W+1)'(STROBE_CYC)));

   assert_strobe_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_rd_n || !dev_wr_n) |-> (dev_cs0_n != dev_cs1_n));

   assert_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_rd_n || !dev_wr_n) |=> ((dev_rd_n && dev_wr_n) || $stable(dev_addr)));

   assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dev_rd_n && !dev_wr_n));

endmodule

// File: rtl/ata_id_timer.sv
module ata_id_timer #(
   parameter int LIMIT = 250_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic expired
);

   localparam int CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("ata_id_timer: limit must be positive");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clear)    cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == CW'(LIMIT));

   assert_clear_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !expired);

   assert_expiry_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !clear) |=> expired);

endmodule

// File: rtl/ata_id_window.sv
module ata_id_window
   import ata_id_pkg::*;
(
   input  logic [SEL_W-1:0]  sel,
   input  logic [WORD_W-1:0] word_idx,
   output logic              sel_ok,
   output logic              hit,
   output logic              last_word,
   output logic              swap
);

   win_t          w;
   logic [WORD_W:0] lo_b;
   logic [WORD_W:0] hi_b;
   logic [WORD_W:0] idx_x;

   always_comb begin
      w         = field_window(sel);
      lo_b      = {1'b0, w.first};
      hi_b      = lo_b + {1'b0, w.count};
      idx_x     = {1'b0, word_idx};
      sel_ok    = w.ok;
      swap      = w.swap;
      hit       = w.ok && (idx_x >= lo_b) && (idx_x < hi_b);
      last_word = w.ok && (idx_x == hi_b - 1'b1);
   end

endmodule

// File: rtl/ata_ident_fetch.sv
module ata_ident_fetch
   import ata_id_pkg::*;
#(
   parameter int STROBE_CYC  = 3,
   parameter int RECOV_CYC   = 2,
   parameter int TIMEOUT_CYC = 250_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   output logic       req_ready,
   input  logic [2:0] req_sel,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data,
   output logic       out_last,
   output logic       resp_valid,
   output logic [1:0] resp_code,
   output logic [2:0] dev_addr,
   output logic       dev_cs0_n,
   output logic       dev_cs1_n,
   output logic       dev_rd_n,
   output logic       dev_wr_n,
   output logic [7:0] dev_dout,
   output logic       dev_doe,
   input  logic [7:0] dev_din
);

   generate
      if (SEL_W != 3 || WORD_W != 8) begin : g_bad_pkg
         $error("ata_ident_fetch: selector or word index width mismatch");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_POLL, S_LO, S_HI, S_EMIT0, S_EMIT1, S_ALT, S_STAT, S_RESP
   } state_e;

   state_e            st;
   logic              pend;
   logic [SEL_W-1:0]  sel_q;
   logic [WORD_W-1:0] widx;
   logic [7:0]        lo_q;
   logic [7:0]        hi_q;
   resp_code_e        code_q;

   logic              bus_start, bus_wr, bus_alt, bus_busy, bus_done;
   logic [2:0]        bus_addr;
   logic [7:0]        bus_rdata;
   logic              tmr_clr, tmr_exp;
   logic [SEL_W-1:0]  sel_mux;
   logic              win_ok, win_hit, win_last, win_swap;
   logic              bus_phase, dev_ready;

   assign sel_mux = (st == S_IDLE) ? req_sel : sel_q;

   ata_id_window u_win (
      .sel       (sel_mux),
      .word_idx  (widx),
      .sel_ok    (win_ok),
      .hit       (win_hit),
      .last_word (win_last),
      .swap      (win_swap)
   );

   always_comb begin
      bus_phase = (st == S_CMD) || (st == S_POLL) || (st == S_LO) ||
                  (st == S_HI)  || (st == S_ALT)  || (st == S_STAT);
      bus_start = bus_phase && !pend && !bus_busy;
      bus_wr    = (st == S_CMD);
      bus_alt   = (st == S_ALT);
      case (st)
         S_LO, S_HI: bus_addr = ADR_DATA;
         S_ALT:      bus_addr = ADR_ALTSTAT;
         default:    bus_addr = ADR_STATUS;
      endcase
      dev_ready = !bus_rdata[BIT_BSY] && bus_rdata[BIT_DRQ];
      tmr_clr   = (st == S_CMD) && pend && bus_done;
   end

   ata_bus_cycle #(
      .STROBE_CYC (STROBE_CYC),
      .RECOV_CYC  (RECOV_CYC),
      .ADDR_W     (3),
      .DATA_W     (8)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (bus_start),
      .wr        (bus_wr),
      .alt       (bus_alt),
      .addr      (bus_addr),
      .wdata     (CMD_IDENTIFY),
      .busy      (bus_busy),
      .done      (bus_done),
      .rdata     (bus_rdata),
      .dev_addr  (dev_addr),
      .dev_cs0_n (dev_cs0_n),
      .dev_cs1_n (dev_cs1_n),
      .dev_rd_n  (dev_rd_n),
      .dev_wr_n  (dev_wr_n),
      .dev_dout  (dev_dout),
      .dev_doe   (dev_doe),
      .dev_din   (dev_din)
   );

   ata_id_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (tmr_clr),
      .expired (tmr_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         pend   <= 1'b0;
         sel_q  <= '0;
         widx   <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         code_q <= RC_OK;
      end else begin
         if (bus_start) pend <= 1'b1;
         case (st)
            S_IDLE: begin
               if (req_valid) begin
                  sel_q <= req_sel;
                  if (win_ok) begin
                     st <= S_CMD;
                  end else begin
                     code_q <= RC_PARAM;
                     st     <= S_RESP;
                  end
               end
            end
            S_CMD: begin
               if (pend && bus_done) begin
                  pend <= 1'b0;
                  st   <= S_POLL;
               end
            end
            S_POLL: begin
               if (pend && bus_done) begin
                  pend <= 1'b0;
                  if (dev_ready) begin
                     widx <= '0;
                     st   <= S_LO;
                  end else if (tmr_exp) begin
                     code_q <= RC_TIMEOUT;
                     st     <= S_RESP;
                  end
               end
            end
            S_LO: begin
               if (pend && bus_done) begin
                  pend <= 1'b0;
                  lo_q <= bus_rdata;
                  st   <= S_HI;
               end
            end
            S_HI: begin
               if (pend && bus_done) begin
                  pend <= 1'b0;
                  hi_q <= bus_rdata;
                  if (win_hit) begin
                     st <= S_EMIT0;
                  end else if (widx == '1) begin
                     st <= S_ALT;
                  end else begin
                     widx <= widx + 1'b1;
                     st   <= S_LO;
                  end
               end
            end
            S_EMIT0: begin
               if (out_ready) st <= S_EMIT1;
            end
            S_EMIT1: begin
               if (out_ready) begin
                  if (widx == '1) begin
                     st <= S_ALT;
                  end else begin
                     widx <= widx + 1'b1;
                     st   <= S_LO;
                  end
               end
            end
            S_ALT: begin
               if (pend && bus_done) begin
                  pend <= 1'b0;
                  st   <= S_STAT;
               end
            end
            S_STAT: begin
               if (pend && bus_done) begin
                  pend   <= 1'b0;
                  code_q <= RC_OK;
                  st     <= S_RESP;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready  = (st == S_IDLE);
      out_valid  = (st == S_EMIT0) || (st == S_EMIT1);
      if (st == S_EMIT0) out_data = win_swap ? hi_q : lo_q;
      else               out_data = win_swap ? lo_q : hi_q;
      out_last   = (st == S_EMIT1) && win_last;
      resp_valid = (st == S_RESP);
      resp_code  = code_q;
   end

   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   assert_bad_sel_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !win_ok) |=> (resp_valid && resp_code == RC_PARAM));

   assert_out_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> win_hit);

   assert_idle_bus_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_busy && dev_cs0_n && dev_cs1_n));

   assert_timeout_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_code == RC_TIMEOUT) |-> $past(st == S_POLL));

endmodule

// File: tb/ata_ident_fetch_test.sv
`timescale 1ns/1ps
module ata_ident_fetch_test;

   localparam int TMO = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [2:0] req_sel = 3'd0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;
   logic       out_last;
   logic       resp_valid;
   logic [1:0] resp_code;
   logic [2:0] dev_addr;
   logic       dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_doe;
   logic [7:0] dev_dout;
   logic [7:0] dev_din;

   always #2 clk = ~clk;

   ata_ident_fetch #(.STROBE_CYC(2), .RECOV_CYC(1), .TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .resp_valid(resp_valid), .resp_code(resp_code),
      .dev_addr(dev_addr), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
      .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_dout(dev_dout), .dev_doe(dev_doe),
      .dev_din(dev_din)
   );

   integer checks = 0;
   integer failures = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i);
      logic [7:0] a;
      a = 8'((i * 37) + 11);
      if (i >= 256) a = a ^ 8'hA5;
      return a;
   endfunction

   // ---------------- device model ----------------
   logic [7:0] rd_byte = 8'h00;
   assign dev_din = rd_byte;
   integer busy_polls = 0;
   integer polls_req = 0, data_req = 0, early_data = 0, post_seq = 0;
   integer tot_wr = 0, tot_strobe = 0, cmd_seen = 0;
   logic [7:0] last_wdata = 8'h00;
   logic [2:0] last_waddr = 3'd0;
   logic       last_wcs0 = 1'b0;

   always @(negedge dev_rd_n or negedge dev_wr_n) begin
      if (rst_n) begin
         tot_strobe++;
         if (!dev_wr_n) begin
            tot_wr++;
            last_wdata = dev_dout;
            last_waddr = dev_addr;
            last_wcs0  = !dev_cs0_n && dev_doe;
            if (!dev_cs0_n && dev_addr == 3'd7) begin
               cmd_seen++;
               polls_req = 0; data_req = 0; early_data = 0; post_seq = 0;
            end
         end else if (!dev_cs0_n && dev_addr == 3'd0) begin
            if (polls_req <= busy_polls) early_data++;
            rd_byte = pat(data_req);
            data_req++;
         end else if (!dev_cs0_n && dev_addr == 3'd7) begin
            if (data_req == 0) begin
               polls_req++;
               if (polls_req > busy_polls) rd_byte = 8'h58;
               else if (polls_req % 2 == 1) rd_byte = 8'h88;
               else rd_byte = 8'h40;
            end else begin
               rd_byte = 8'h50;
               if (data_req >= 512) post_seq = post_seq * 4 + 2;
            end
         end else if (!dev_cs1_n && dev_addr == 3'd6) begin
            rd_byte = 8'h50;
            if (data_req >= 512) post_seq = post_seq * 4 + 1;
         end else begin
            rd_byte = 8'hFF;
            post_seq = post_seq * 4 + 3;
         end
      end
   end

   // ---------------- reference stream and monitor ----------------
   logic [7:0] exp_q[$];
   bit     bp_on = 1'b0;
   integer rdy_cnt = 0, byte_cnt = 0, last_cnt = 0, resp_n = 0;
   bit     resp_got = 1'b0;
   logic [1:0] resp_c = 2'd0;

   initial begin
      forever begin
         @(negedge clk);
         out_ready = bp_on ? ((rdy_cnt % 3) != 1) : 1'b1;
         rdy_cnt++;
         if (out_valid && out_ready) begin
            byte_cnt++;
            if (out_last) last_cnt++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 byte outside window", out_data, 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(out_data == e, "R7 byte value/order", out_data, e);
               chk(out_last == (exp_q.size() == 0), "R8 last flag", out_last, exp_q.size() == 0);
            end
         end
         if (resp_valid) begin
            resp_got = 1'b1;
            resp_c   = resp_code;
            resp_n++;
         end
      end
   end

   task automatic build_exp(input int sel);
      int off, len;
      bit sw;
      exp_q.delete();
      case (sel)
         0: begin off = 60; len = 2;  sw = 0; end
         1: begin off = 23; len = 4;  sw = 1; end
         2: begin off = 27; len = 20; sw = 1; end
         3: begin off = 10; len = 10; sw = 1; end
         default: begin off = 0; len = 0; sw = 0; end
      endcase
      for (int w = off; w < off + len; w++) begin
         if (sw) begin exp_q.push_back(pat(2*w+1)); exp_q.push_back(pat(2*w)); end
         else    begin exp_q.push_back(pat(2*w));   exp_q.push_back(pat(2*w+1)); end
      end
   endtask

   task automatic wait_resp();
      int n;
      n = 0;
      while (!resp_got && n < 30000) begin
         @(negedge clk);
         n++;
      end
      chk(resp_got, "R9 response seen", resp_got, 1);
   endtask

   task automatic run_ok(input int sel, input int busy, input bit bp, input bit probe);
      int wr0, resp0, bytes0, last0, nexp;
      @(negedge clk);
      busy_polls = busy;
      bp_on = bp;
      build_exp(sel);
      nexp = exp_q.size();
      wr0 = tot_wr; resp0 = resp_n; bytes0 = byte_cnt; last0 = last_cnt;
      resp_got = 1'b0;
      chk(req_ready == 1'b1, "R11 ready when idle", req_ready, 1);
      req_valid = 1'b1;
      req_sel = 3'(sel);
      @(negedge clk);
      req_valid = 1'b0;
      if (probe) begin
         repeat (30) @(negedge clk);
         for (int k = 0; k < 8; k++) begin
            req_valid = 1'b1;
            req_sel = 3'd5;
            @(negedge clk);
            chk(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
         end
         req_valid = 1'b0;
      end
      wait_resp();
      @(negedge clk);
      chk(resp_c == 2'd0, "R9 success code", resp_c, 0);
      chk(resp_n - resp0 == 1, "R11 single response", resp_n - resp0, 1);
      chk(tot_wr - wr0 == 1, "R2 one write", tot_wr - wr0, 1);
      chk(last_wdata == 8'hEC && last_waddr == 3'd7 && last_wcs0, "R2 command write",
          {last_wcs0, last_waddr, last_wdata}, {1'b1, 3'd7, 8'hEC});
      chk(early_data == 0, "R3 no early data read", early_data, 0);
      chk(polls_req == busy + 1, "R3 poll count", polls_req, busy + 1);
      chk(data_req == 512, "R5 data read count", data_req, 512);
      chk(post_seq == 6, "R9 alt then status", post_seq, 6);
      chk(byte_cnt - bytes0 == nexp, "R6 window byte count", byte_cnt - bytes0, nexp);
      chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
      chk(last_cnt - last0 == 1, "R8 one last flag", last_cnt - last0, 1);
      bp_on = 1'b0;
   endtask

   task automatic run_bad(input int sel);
      int s0, b0;
      @(negedge clk);
      exp_q.delete();
      s0 = tot_strobe; b0 = byte_cnt;
      resp_got = 1'b0;
      req_valid = 1'b1;
      req_sel = 3'(sel);
      @(negedge clk);
      req_valid = 1'b0;
      chk(resp_valid == 1'b1 && resp_code == 2'd1, "R1 parameter error next cycle",
          {resp_valid, resp_code}, 3'b101);
      repeat (10) @(negedge clk);
      chk(req_ready == 1'b1, "R1 back to idle", req_ready, 1);
      chk(tot_strobe == s0, "R1 no bus strobes", tot_strobe - s0, 0);
      chk(dev_cs0_n && dev_cs1_n, "R1 chip selects idle", {dev_cs0_n, dev_cs1_n}, 2'b11);
      chk(byte_cnt == b0, "R1 no output", byte_cnt - b0, 0);
   endtask

   task automatic run_timeout(input int sel);
      int b0;
      @(negedge clk);
      busy_polls = 1000000;
      exp_q.delete();
      b0 = byte_cnt;
      resp_got = 1'b0;
      req_valid = 1'b1;
      req_sel = 3'(sel);
      @(negedge clk);
      req_valid = 1'b0;
      wait_resp();
      chk(resp_c == 2'd2, "R4 timeout code", resp_c, 2);
      chk(data_req == 0, "R4 no data reads", data_req, 0);
      chk(byte_cnt == b0, "R4 no output bytes", byte_cnt - b0, 0);
      chk(polls_req > TMO / 10, "R4 polled until limit", polls_req, TMO / 10);
   endtask

   initial begin
      #(4 * 190000);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && !out_valid && !resp_valid, "R11 reset state",
          {req_ready, out_valid, resp_valid}, 3'b100);
      chk(dev_cs0_n && dev_cs1_n && dev_rd_n && dev_wr_n && !dev_doe, "R10 bus idle at reset",
          {dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n, dev_doe}, 5'b11110);

      run_ok(0, 3, 1'b0, 1'b0);
      run_ok(1, 0, 1'b1, 1'b0);
      run_ok(2, 5, 1'b1, 1'b0);
      run_ok(3, 2, 1'b0, 1'b1);
      run_bad(5);
      run_bad(7);
      run_timeout(2);
      run_ok(0, 1, 1'b1, 1'b0);

      repeat (5) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule